// File: doc/BRIEF.md
# Halfword-Select Signed Multiply-Accumulate Unit

This unit performs one signed multiply per issue for signal-processing code. Both 32-bit operands can hold two packed 16-bit values. Two select bits pick which halves take part. A 2-bit operation code chooses one of five operations:

- a 16x16 product, returned alone;
- a 16x16 product added to a 32-bit accumulator;
- a 16x16 product added to a 64-bit accumulator;
- the upper 32 bits of a 32x16 product, returned alone;
- the upper 32 bits of a 32x16 product, added to a 32-bit accumulator.

The result is registered and appears one cycle after issue. The 32-bit accumulations wrap rather than saturate. A signed overflow in one of them sets a sticky overflow flag, and that flag stays set until the surrounding logic clears it. The unit has no condition-flag outputs, so it cannot change them.

Top module: `hsmac_unit`

## Requirements
- R1: With `op`=11, `res_lo` is the 32-bit signed product of the halfword of `opnd_a` picked by `sel_a` and the halfword of `opnd_b` picked by `sel_b`. Each select bit means 0 = bits 15:0 and 1 = bits 31:16.
- R2: With `op`=00, `res_lo` is that 16x16 product plus `acc_lo`, wrapping modulo 2^32.
- R3: With `op`=10, {`res_hi`,`res_lo`} is {`acc_hi`,`acc_lo`} plus the sign-extended 16x16 product, modulo 2^64, with the carry passing between the two words.
- R4: With `op`=01 and `sel_a`=0, `res_lo` is bits 47:16 of the signed product of all of `opnd_a` and the `sel_b` halfword of `opnd_b`, plus `acc_lo`, wrapping.
- R5: With `op`=01 and `sel_a`=1, `res_lo` is bits 47:16 of that 32x16 product, and `acc_lo` has no effect.
- R6: For `op`=00, and for `op`=01 with `sel_a`=0, a signed overflow of the 32-bit addition sets `q_flag` in the cycle the result appears.
- R7: `q_flag` stays set once set. `op`=10, `op`=11 and `op`=01 with `sel_a`=1 never set it, whatever their values.
- R8: `q_clear` clears `q_flag` at the next edge, whether or not `valid_in` is high. An overflow on an issue in that same cycle wins, and the flag stays 1.
- R9: `valid_out` is `valid_in` delayed by one cycle. Results change only on a valid issue and hold otherwise. `res_hi` is 0 after any operation other than `op`=10.
- R10: While `rst_n` is low, `valid_out`, `q_flag`, `res_lo` and `res_hi` are all 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Issue strobe |
| op | input | 2 | Operation code |
| sel_a | input | 1 | Halfword select for opnd_a; in op 01, 1 = no accumulate |
| sel_b | input | 1 | Halfword select for opnd_b |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| acc_lo | input | 32 | Accumulator, low word |
| acc_hi | input | 32 | Accumulator, high word (op 10 only) |
| q_clear | input | 1 | Clears the sticky overflow flag |
| valid_out | output | 1 | Result valid |
| res_lo | output | 32 | Result, low word |
| res_hi | output | 32 | Result, high word |
| q_flag | output | 1 | Sticky overflow flag |

## Verification
The multiplier is tried with operands that hold different signed values in each half, under all four select combinations. A swapped or misread halfword therefore gives a different number. The accumulate paths are tried with values that bring the sum just across the signed limit, with a low-word carry into the high word, and with negative products in the 64-bit path. These cases separate a wrapping add from a saturating one and a sign-extended product from a zero-extended one. Large results from the modes that do not accumulate, a clear issued alone, and a clear issued together with an overflow confirm which operations may set or clear the flag.

// File: rtl/hsmac_pkg.sv
package hsmac_pkg;
   typedef enum logic [1:0] {
      OP_MAC16 = 2'b00,
      OP_W32   = 2'b01,
      OP_MACL  = 2'b10,
      OP_MUL16 = 2'b11
   } hsmac_op_e;
endpackage

// File: rtl/hsmac_opsel.sv
module hsmac_opsel
   import hsmac_pkg::*;
#(
   parameter int HALF_W = 16,
   localparam int WORD_W = 2 * HALF_W
) (
   input  hsmac_op_e          op,
   input  logic               sel_a,
   input  logic               sel_b,
   input  logic [WORD_W-1:0]  opnd_a,
   input  logic [WORD_W-1:0]  opnd_b,
   output logic [WORD_W-1:0]  mul_a,
   output logic [HALF_W-1:0]  mul_b
);
   logic [HALF_W-1:0] halves_a [2];
   logic [HALF_W-1:0] halves_b [2];

   for (genvar g = 0; g < 2; g++) begin : g_split
      assign halves_a[g] = opnd_a[g*HALF_W +: HALF_W];
      assign halves_b[g] = opnd_b[g*HALF_W +: HALF_W];
   end

   logic [HALF_W-1:0] pick_a;
   assign pick_a = halves_a[sel_a];
   assign mul_b  = halves_b[sel_b];

   // the 32x16 mode uses all of opnd_a; the others a sign-extended half
   always_comb begin
      if (op == OP_W32) mul_a = opnd_a;
      else              mul_a = {{HALF_W{pick_a[HALF_W-1]}}, pick_a};
   end
endmodule

// File: rtl/hsmac_mult.sv
module hsmac_mult #(
   parameter int HALF_W = 16,
   localparam int WORD_W = 2 * HALF_W,
   localparam int PROD_W = 3 * HALF_W
) (
   input  logic [WORD_W-1:0] mul_a,
   input  logic [HALF_W-1:0] mul_b,
   output logic [PROD_W-1:0] prod
);
   logic [PROD_W-1:0] ext_a;
   logic [PROD_W-1:0] ext_b;
   assign ext_a = {{HALF_W{mul_a[WORD_W-1]}}, mul_a};
   assign ext_b = {{WORD_W{mul_b[HALF_W-1]}}, mul_b};
   // low PROD_W bits of the extended product are the exact signed result
   assign prod  = ext_a * ext_b;
endmodule

// File: rtl/hsmac_accum.sv
module hsmac_accum
   import hsmac_pkg::*;
#(
   parameter int HALF_W = 16,
   localparam int WORD_W = 2 * HALF_W,
   localparam int PROD_W = 3 * HALF_W,
   localparam int DWORD_W = 4 * HALF_W
) (
   input  hsmac_op_e          op,
   input  logic               sel_a,
   input  logic [PROD_W-1:0]  prod,
   input  logic [WORD_W-1:0]  acc_lo,
   input  logic [WORD_W-1:0]  acc_hi,
   output logic [WORD_W-1:0]  sum_lo,
   output logic [WORD_W-1:0]  sum_hi,
   output logic               ovf
);
   logic [WORD_W-1:0]  prod_short;
   logic [WORD_W-1:0]  prod_top;
   logic [WORD_W-1:0]  addend;
   logic [WORD_W-1:0]  sum32;
   logic [DWORD_W-1:0] sum64;
   logic               add32;

   assign prod_short = prod[WORD_W-1:0];
   assign prod_top   = prod[PROD_W-1:HALF_W];

   always_comb begin
      addend = prod_short;
      add32  = 1'b0;
      unique case (op)
         OP_MAC16: add32 = 1'b1;
         OP_W32: begin
            addend = prod_top;
            add32  = ~sel_a;
         end
         default: ;
      endcase
   end

   assign sum32 = addend + acc_lo;
   assign sum64 = {acc_hi, acc_lo} + {{WORD_W{prod_short[WORD_W-1]}}, prod_short};

   always_comb begin
      sum_hi = '0;
      if (op == OP_MACL) {sum_hi, sum_lo} = sum64;
      else if (add32)    sum_lo = sum32;
      else               sum_lo = addend;
   end

   // like-signed addends giving an opposite-signed sum
   assign ovf = add32 && (addend[WORD_W-1] == acc_lo[WORD_W-1])
                      && (sum32[WORD_W-1] != addend[WORD_W-1]);

   always_comb begin
      if (op == OP_MACL || op == OP_MUL16)
         a_r7_no_ovf_modes: assert (!ovf);
   end
endmodule

// File: rtl/hsmac_qflag.sv
module hsmac_qflag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic clr_req,
   output logic q
);
   logic q_next;

   if (SET_WINS) begin : g_set_wins
      assign q_next = (q & ~clr_req) | set_req;
   end else begin : g_clr_wins
      assign q_next = (q | set_req) & ~clr_req;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= q_next;
   end

   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      q && !clr_req |=> q);
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req && !set_req |=> !q);
   a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
      set_req && !clr_req |=> q);
endmodule

// File: rtl/hsmac_unit.sv
module hsmac_unit
   import hsmac_pkg::*;
#(
   parameter int HALF_W = 16,
   parameter bit Q_SET_WINS = 1'b1,
   localparam int WORD_W = 2 * HALF_W,
   localparam int PROD_W = 3 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_in,
   input  logic [1:0]        op,
   input  logic              sel_a,
   input  logic              sel_b,
   input  logic [WORD_W-1:0] opnd_a,
   input  logic [WORD_W-1:0] opnd_b,
   input  logic [WORD_W-1:0] acc_lo,
   input  logic [WORD_W-1:0] acc_hi,
   input  logic              q_clear,
   output logic              valid_out,
   output logic [WORD_W-1:0] res_lo,
   output logic [WORD_W-1:0] res_hi,
   output logic              q_flag
);
   if (HALF_W < 2) begin : g_bad_width
      $error("hsmac_unit: HALF_W must be at least 2");
   end

   hsmac_op_e         op_e;
   logic [WORD_W-1:0] mul_a;
   logic [HALF_W-1:0] mul_b;
   logic [PROD_W-1:0] prod;
   logic [WORD_W-1:0] sum_lo;
   logic [WORD_W-1:0] sum_hi;
   logic              ovf;

   assign op_e = hsmac_op_e'(op);

   hsmac_opsel #(.HALF_W(HALF_W)) u_opsel (
      .op(op_e), .sel_a(sel_a), .sel_b(sel_b),
      .opnd_a(opnd_a), .opnd_b(opnd_b),
      .mul_a(mul_a), .mul_b(mul_b)
   );

   hsmac_mult #(.HALF_W(HALF_W)) u_mult (
      .mul_a(mul_a), .mul_b(mul_b), .prod(prod)
   );

   hsmac_accum #(.HALF_W(HALF_W)) u_accum (
      .op(op_e), .sel_a(sel_a), .prod(prod),
      .acc_lo(acc_lo), .acc_hi(acc_hi),
      .sum_lo(sum_lo), .sum_hi(sum_hi), .ovf(ovf)
   );

   hsmac_qflag #(.SET_WINS(Q_SET_WINS)) u_qflag (
      .clk(clk), .rst_n(rst_n),
      .set_req(valid_in & ovf), .clr_req(q_clear),
      .q(q_flag)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_out <= 1'b0;
         res_lo    <= '0;
         res_hi    <= '0;
      end else begin
         valid_out <= valid_in;
         if (valid_in) begin
            res_lo <= sum_lo;
            res_hi <= sum_hi;
         end
      end
   end

   a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
      valid_in |=> valid_out);
   a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_in |=> !valid_out && $stable(res_lo) && $stable(res_hi));
   a_r9_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
      valid_in && op != 2'b10 |=> res_hi == '0);
   a_r7_no_set_plain: assert property (@(posedge clk) disable iff (!rst_n)
      valid_in && (op == 2'b11 || op == 2'b10) && !q_flag |=> !q_flag);
   a_r10_reset: assert property (@(posedge clk)
      !rst_n |=> !valid_out && !q_flag && res_lo == '0 && res_hi == '0);
endmodule

// File: tb/sim_hsmac_unit.sv
module sim_hsmac_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_in = 1'b0;
   logic [1:0]  op = 2'b00;
   logic        sel_a = 1'b0;
   logic        sel_b = 1'b0;
   logic [31:0] opnd_a = '0;
   logic [31:0] opnd_b = '0;
   logic [31:0] acc_lo = '0;
   logic [31:0] acc_hi = '0;
   logic        q_clear = 1'b0;
   logic        valid_out;
   logic [31:0] res_lo;
   logic [31:0] res_hi;
   logic        q_flag;

   int n_chk = 0;
   int n_fail = 0;
   bit q_exp = 1'b0;

   always #4 clk = ~clk;

   hsmac_unit u0 (
      .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op(op),
      .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .acc_lo(acc_lo), .acc_hi(acc_hi), .q_clear(q_clear),
      .valid_out(valid_out), .res_lo(res_lo), .res_hi(res_hi), .q_flag(q_flag)
   );

   task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic longint half_of(logic [31:0] w, bit hi);
      logic [15:0] h;
      h = hi ? w[31:16] : w[15:0];
      return longint'($signed(h));
   endfunction

   // expected model, written from the requirements
   task automatic issue(string req, logic [1:0] o, bit x, bit y, logic [31:0] a,
                        logic [31:0] b, logic [31:0] lo, logic [31:0] hi, bit clr);
      longint p, s;
      logic [63:0] e64;
      logic [31:0] elo;
      logic [31:0] ehi;
      bit ov;
      ov = 1'b0; ehi = '0;
      case (o)
         2'b11: begin p = half_of(a, x) * half_of(b, y); elo = p[31:0]; end
         2'b00: begin
            p = half_of(a, x) * half_of(b, y);
            s = p + longint'($signed(lo));
            elo = s[31:0];
            ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
         end
         2'b10: begin
            p = half_of(a, x) * half_of(b, y);
            e64 = {hi, lo} + p;
            {ehi, elo} = e64;
         end
         default: begin
            p = longint'($signed(a)) * half_of(b, y);
            p = p >>> 16;
            if (x) elo = p[31:0];
            else begin
               s = longint'($signed(p[31:0])) + longint'($signed(lo));
               elo = s[31:0];
               ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            end
         end
      endcase
      q_exp = (q_exp & ~clr) | ov;
      @(negedge clk);
      valid_in = 1'b1; op = o; sel_a = x; sel_b = y;
      opnd_a = a; opnd_b = b; acc_lo = lo; acc_hi = hi; q_clear = clr;
      @(negedge clk);
      valid_in = 1'b0; q_clear = 1'b0;
      check("R9", "valid_out", 64'(valid_out), 64'd1);
      check(req, "res_lo", 64'(res_lo), 64'(elo));
      check(req == "R3" ? "R3" : "R9", "res_hi", 64'(res_hi), 64'(ehi));
      check(ov ? "R6" : (clr ? "R8" : "R7"), "q_flag", 64'(q_flag), 64'(q_exp));
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R10", "valid_out", 64'(valid_out), 64'd0);
      check("R10", "q_flag", 64'(q_flag), 64'd0);
      check("R10", "res", {res_hi, res_lo}, 64'd0);
      rst_n = 1'b1;
   endtask

   task automatic t_mul16();
      for (int k = 0; k < 4; k++)
         issue("R1", 2'b11, k[1], k[0], 32'h7FFF_8000, 32'h0003_FFFE, 32'h1111_1111, 32'h2222_2222, 1'b0);
   endtask

   task automatic t_macl();
      issue("R3", 2'b10, 1'b0, 1'b0, 32'h0000_0001, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0);
      issue("R3", 2'b10, 1'b1, 1'b0, 32'hFFFF_0000, 32'h0000_0001, 32'h0, 32'h0, 1'b0);
      issue("R7", 2'b10, 1'b0, 1'b1, 32'h0000_8000, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0, 1'b0);
   endtask

   task automatic t_w32();
      issue("R4", 2'b01, 1'b0, 1'b1, 32'h1234_5678, 32'h8000_0001, 32'h0000_0005, 32'h0, 1'b0);
      issue("R5", 2'b01, 1'b1, 1'b0, 32'hF234_5678, 32'h0001_7FFF, 32'h7FFF_FFFF, 32'h0, 1'b0);
      issue("R5", 2'b01, 1'b1, 1'b1, 32'h8000_0000, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0, 1'b0);
   endtask

   task automatic t_mac16();
      issue("R2", 2'b00, 1'b0, 1'b0, 32'h0000_03E8, 32'h0000_FFFD, 32'd50, 32'h0, 1'b0);
      issue("R2", 2'b00, 1'b1, 1'b0, 32'h8000_0000, 32'h0000_8000, 32'h4000_0000, 32'h0, 1'b0);
   endtask

   task automatic t_sticky_clear();
      issue("R7", 2'b11, 1'b0, 1'b0, 32'h0000_7FFF, 32'h0000_7FFF, 32'h0, 32'h0, 1'b0);
      issue("R8", 2'b11, 1'b0, 1'b0, 32'h0000_0002, 32'h0000_0003, 32'h0, 32'h0, 1'b1);
      issue("R6", 2'b01, 1'b0, 1'b0, 32'h7FFF_FFFF, 32'h0000_7FFF, 32'h7FFF_0000, 32'h0, 1'b0);
      issue("R8", 2'b00, 1'b0, 1'b0, 32'h0000_8000, 32'h0000_8000, 32'h4000_0000, 32'h0, 1'b1);
      // clear with no issue
      @(negedge clk);
      q_clear = 1'b1;
      @(negedge clk);
      q_clear = 1'b0;
      q_exp = 1'b0;
      check("R8", "q_flag clear alone", 64'(q_flag), 64'd0);
   endtask

   task automatic t_hold();
      logic [31:0] lo0, hi0;
      lo0 = res_lo; hi0 = res_hi;
      @(negedge clk);
      op = 2'b10; opnd_a = 32'hDEAD_BEEF; opnd_b = 32'h1234_5678;
      acc_lo = 32'h5555_5555; acc_hi = 32'hAAAA_AAAA;
      repeat (2) @(negedge clk);
      check("R9", "valid_out idle", 64'(valid_out), 64'd0);
      check("R9", "res hold", {res_hi, res_lo}, {hi0, lo0});
   endtask

   initial begin
      #(8 * 50000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_mul16();
      t_macl();
      t_w32();
      t_hold();
      t_mac16();
      t_sticky_clear();
      t_hold();
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule